// File: doc/BRIEF.md
# Stack and Vector Sequencer for an 8-bit CPU Core

This block runs the memory traffic for the control-flow operations of a small 8-bit processor that touch the hardware stack or an interrupt vector: subroutine call, subroutine return, software break, return from interrupt and non-maskable interrupt entry. The decoder hands it an operation code, the program counter value to save and, for a call, the destination address. The block then steps through one memory access per clock. It drives the address, the write data and the read or write strobe. Along the way it updates the program counter, stack pointer and status register that it owns. A one-cycle `done` pulse follows the last access.

The stack is a single 256-byte page at 0x0100. Pushes store the high byte of the program counter before the low byte, so pops recover the low byte first. A call saves the address of its own last operand byte, and the matching return adds one to the value it pops. Break and non-maskable interrupt entry both save the status byte after the program counter. They differ only in the break flag of the saved byte and in the vector pair they read. A new request is accepted in any cycle in which no sequence is running, including the cycle that carries `done` for the previous sequence.

Top module: `stack_vector_seq`

## Requirements
- R1: After reset the program counter reads 0x0000, the stack pointer 0xFF and the status register 0x04, with `busy`, `done`, `mem_rd` and `mem_wr` all low.
- R2: Operation code 0 (call) writes `req_pc[15:8]` to 0x0100+SP and then `req_pc[7:0]` to the next lower stack address. It leaves SP two lower and loads the program counter with `req_target`.
- R3: Operation code 1 (return) reads the low byte at 0x0100+SP+1 and then the high byte one address above. It leaves SP two higher and loads the program counter with the popped 16-bit value plus one.
- R4: Operation code 2 (break) pushes `req_pc` high, then low, then the status byte with bit 4 forced to 1. It then reads 0xFFFE (low) and 0xFFFF (high) into the program counter and sets status bit 2.
- R5: Operation code 3 (return from interrupt) pops the status byte, then the program counter low byte, then the high byte. It loads both registers with the popped values, with no increment.
- R6: Operation code 4 (non-maskable interrupt) pushes `req_pc` high, then low, then the status byte with bit 4 forced to 0. It then reads 0xFFFA (low) and 0xFFFB (high) into the program counter and sets status bit 2.
- R7: A push writes at 0x0100+SP and then decrements SP. A pop increments SP and then reads at 0x0100+SP. SP wraps modulo 256, so every stack access lies in 0x0100–0x01FF.
- R8: The first access appears in the cycle after the request is taken, and each later access follows in the next cycle. `mem_rd` and `mem_wr` are never high together. `done` is high for exactly one cycle, the cycle after the final access.
- R9: A request made while a sequence is running, or with an operation code of 5, 6 or 7, causes no memory access and no `done`, and changes no register.
- R10: A request presented in the cycle in which `done` is high is accepted, and its first access appears in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operation request |
| req_op | input | 3 | Operation code: 0 call, 1 return, 2 break, 3 return from interrupt, 4 non-maskable interrupt |
| req_pc | input | 16 | Program counter value to push |
| req_target | input | 16 | Call destination |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_rd | output | 1 | Read strobe; data returned on mem_rdata in the same cycle |
| mem_wr | output | 1 | Write strobe |
| mem_rdata | input | 8 | Read data |
| pc_out | output | 16 | Program counter |
| sp_out | output | 8 | Stack pointer |
| status_out | output | 8 | Status register |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two functions can fall in the same cycle: the completion pulse of one sequence and the acceptance of the next request. The bench waits for `busy` to drop before each request. Successive operations are therefore issued exactly in the `done` cycle of their predecessor, and for each one the bench checks that the first access of the new sequence shows up in the very next cycle. The scoreboard then judges the whole chain. Stack contents written by one sequence (break, call) are read back by a later one (return, return from interrupt), so any byte-order or pointer error pushes later addresses, data or final register values away from the bench's own model.

// File: rtl/stack_vector_seq.sv
module stack_vector_seq #(
  parameter logic [7:0]  SP_INIT = 8'hFF,
  parameter logic [7:0]  ST_INIT = 8'h04,
  parameter logic [15:0] PC_INIT = 16'h0000,
  parameter int          STEP_W  = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [2:0]  req_op,
  input  logic [15:0] req_pc,
  input  logic [15:0] req_target,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        mem_rd,
  output logic        mem_wr,
  input  logic [7:0]  mem_rdata,
  output logic [15:0] pc_out,
  output logic [7:0]  sp_out,
  output logic [7:0]  status_out,
  output logic        busy,
  output logic        done
);

  localparam logic [2:0]  OP_CALL = 3'd0;
  localparam logic [2:0]  OP_RET  = 3'd1;
  localparam logic [2:0]  OP_BRK  = 3'd2;
  localparam logic [2:0]  OP_RTI  = 3'd3;
  localparam logic [2:0]  OP_NMI  = 3'd4;
  localparam int          BRK_BIT = 4;
  localparam int          IRQ_BIT = 2;
  localparam logic [7:0]  BRK_MASK   = 8'(1 << BRK_BIT);
  localparam logic [7:0]  STACK_PAGE = 8'h01;
  localparam logic [15:0] VEC_BRK    = 16'hFFFE;
  localparam logic [15:0] VEC_NMI    = 16'hFFFA;

  typedef enum logic [2:0] {
    K_WHI, K_WLO, K_WST, K_RST, K_RLO, K_RHI, K_VLO, K_VHI
  } kind_e;

  logic              busy_q, done_q;
  logic [2:0]        op_q;
  logic [STEP_W-1:0] step_q;
  logic [15:0]       ret_q, tgt_q, pc_q;
  logic [7:0]        sp_q, st_q, lo_q;
  kind_e             kind;
  logic              last;

  always_comb begin
    kind = K_WHI;
    last = 1'b0;
    case (op_q)
      OP_CALL: begin
        kind = (step_q == '0) ? K_WHI : K_WLO;
        last = (step_q == STEP_W'(1));
      end
      OP_RET: begin
        kind = (step_q == '0) ? K_RLO : K_RHI;
        last = (step_q == STEP_W'(1));
      end
      OP_RTI: begin
        case (step_q)
          STEP_W'(0): kind = K_RST;
          STEP_W'(1): kind = K_RLO;
          default:    kind = K_RHI;
        endcase
        last = (step_q == STEP_W'(2));
      end
      default: begin
        case (step_q)
          STEP_W'(0): kind = K_WHI;
          STEP_W'(1): kind = K_WLO;
          STEP_W'(2): kind = K_WST;
          STEP_W'(3): kind = K_VLO;
          default:    kind = K_VHI;
        endcase
        last = (step_q == STEP_W'(4));
      end
    endcase
  end

  wire        is_push  = (kind == K_WHI) || (kind == K_WLO) || (kind == K_WST);
  wire        is_vec   = (kind == K_VLO) || (kind == K_VHI);
  wire [7:0]  sp_pop   = sp_q + 8'd1;
  wire [15:0] vec_base = (op_q == OP_NMI) ? VEC_NMI : VEC_BRK;
  wire [7:0]  st_push  = (op_q == OP_NMI) ? (st_q & ~BRK_MASK) : (st_q | BRK_MASK);
  wire        accept   = req_valid && !busy_q && (req_op <= OP_NMI);

  assign mem_addr = is_vec ? (vec_base | {15'd0, kind == K_VHI})
                           : {STACK_PAGE, is_push ? sp_q : sp_pop};
  assign mem_wdata = (kind == K_WHI) ? ret_q[15:8] :
                     (kind == K_WLO) ? ret_q[7:0]  :
                     (kind == K_WST) ? st_push     : 8'h00;
  assign mem_wr     = busy_q && is_push;
  assign mem_rd     = busy_q && !is_push;
  assign pc_out     = pc_q;
  assign sp_out     = sp_q;
  assign status_out = st_q;
  assign busy       = busy_q;
  assign done       = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      op_q   <= OP_CALL;
      step_q <= '0;
      ret_q  <= '0;
      tgt_q  <= '0;
      lo_q   <= '0;
      pc_q   <= PC_INIT;
      sp_q   <= SP_INIT;
      st_q   <= ST_INIT;
    end else begin
      done_q <= busy_q && last;
      if (accept) begin
        busy_q <= 1'b1;
        op_q   <= req_op;
        step_q <= '0;
        ret_q  <= req_pc;
        tgt_q  <= req_target;
      end else if (busy_q) begin
        step_q <= step_q + 1'b1;
        if (last) busy_q <= 1'b0;
        if (is_push)     sp_q <= sp_q - 8'd1;
        else if (!is_vec) sp_q <= sp_pop;
        case (kind)
          K_WLO: if (op_q == OP_CALL) pc_q <= tgt_q;
          K_RST: st_q <= mem_rdata;
          K_RLO, K_VLO: lo_q <= mem_rdata;
          K_RHI: pc_q <= {mem_rdata, lo_q} + ((op_q == OP_RET) ? 16'd1 : 16'd0);
          K_VHI: begin
            pc_q <= {mem_rdata, lo_q};
            st_q[IRQ_BIT] <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/stack_vector_seq_chk.sv
module stack_vector_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic [15:0] mem_addr,
  input logic [7:0]  sp_out,
  input logic [7:0]  status_out,
  input logic        busy,
  input logic        done
);

  a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_after_access: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_rd || mem_wr));

  a_r7_push_in_page: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_addr[15:8] == 8'h01));

  a_r7_push_decrements: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> (sp_out == $past(sp_out) - 8'd1));

  a_r4_r6_vector_masks: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && mem_addr[15:4] == 12'hFFF && mem_addr[0]) |=> status_out[2]);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(mem_rd || mem_wr));

endmodule

bind stack_vector_seq stack_vector_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .mem_addr(mem_addr), .sp_out(sp_out), .status_out(status_out),
  .busy(busy), .done(done)
);

// File: tb/stack_vector_seq_tb_top.sv
module stack_vector_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = 3'd0;
  logic [15:0] req_pc = 16'h0, req_target = 16'h0;
  logic [15:0] mem_addr, pc_out;
  logic [7:0]  mem_wdata, sp_out, status_out;
  logic [7:0]  mem_rdata = 8'h00;
  logic        mem_rd, mem_wr, busy, done;

  always #4 clk = ~clk;

  stack_vector_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_pc(req_pc), .req_target(req_target), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_rdata(mem_rdata), .pc_out(pc_out), .sp_out(sp_out),
    .status_out(status_out), .busy(busy), .done(done)
  );

  logic [7:0]  dut_mem [logic [15:0]];
  logic [7:0]  ref_mem [logic [15:0]];
  logic [24:0] acc_q [$];
  string       acc_tag [$];
  logic [31:0] fin_q [$];
  string       fin_tag [$];
  logic [7:0]  sp_m = 8'hFF, st_m = 8'h04;
  logic [15:0] pc_m = 16'h0000;
  int          checks = 0, fails = 0;
  bit          finished = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rd_of(input bit use_ref, input logic [15:0] a);
    if (use_ref) return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
    return dut_mem.exists(a) ? dut_mem[a] : 8'h00;
  endfunction

  task automatic preload(input logic [15:0] a, input logic [7:0] d);
    dut_mem[a] = d;
    ref_mem[a] = d;
  endtask

  task automatic ref_push(input logic [7:0] d, input string tag);
    acc_q.push_back({1'b1, 8'h01, sp_m, d});
    acc_tag.push_back(tag);
    ref_mem[{8'h01, sp_m}] = d;
    sp_m = sp_m - 8'd1;
  endtask

  task automatic ref_read(input logic [15:0] a, input string tag, output logic [7:0] d);
    acc_q.push_back({1'b0, a, 8'h00});
    acc_tag.push_back(tag);
    d = rd_of(1'b1, a);
  endtask

  task automatic ref_pop(input string tag, output logic [7:0] d);
    sp_m = sp_m + 8'd1;
    ref_read({8'h01, sp_m}, tag, d);
  endtask

  task automatic predict(input logic [2:0] op, input logic [15:0] pc, input logic [15:0] tgt);
    logic [7:0] lo, hi, st;
    string tag;
    case (op)
      3'd0: begin tag = "R2"; ref_push(pc[15:8], tag); ref_push(pc[7:0], tag); pc_m = tgt; end
      3'd1: begin tag = "R3"; ref_pop(tag, lo); ref_pop(tag, hi); pc_m = {hi, lo} + 16'd1; end
      3'd2: begin
        tag = "R4";
        ref_push(pc[15:8], tag); ref_push(pc[7:0], tag); ref_push(st_m | 8'h10, tag);
        ref_read(16'hFFFE, tag, lo); ref_read(16'hFFFF, tag, hi);
        pc_m = {hi, lo}; st_m = st_m | 8'h04;
      end
      3'd3: begin
        tag = "R5";
        ref_pop(tag, st); ref_pop(tag, lo); ref_pop(tag, hi);
        st_m = st; pc_m = {hi, lo};
      end
      default: begin
        tag = "R6";
        ref_push(pc[15:8], tag); ref_push(pc[7:0], tag); ref_push(st_m & 8'hEF, tag);
        ref_read(16'hFFFA, tag, lo); ref_read(16'hFFFB, tag, hi);
        pc_m = {hi, lo}; st_m = st_m | 8'h04;
      end
    endcase
    fin_q.push_back({pc_m, sp_m, st_m});
    fin_tag.push_back(tag);
  endtask

  task automatic issue(input logic [2:0] op, input logic [15:0] pc,
                       input logic [15:0] tgt, input bit valid_op);
    bit was_done;
    @(negedge clk);
    while (busy) @(negedge clk);
    was_done   = done;
    req_valid  = 1'b1;
    req_op     = op;
    req_pc     = pc;
    req_target = tgt;
    if (valid_op) predict(op, pc, tgt);
    @(negedge clk);
    req_valid = 1'b0;
    if (valid_op) begin
      check(mem_rd || mem_wr, "R8", "first access after request", {30'd0, mem_rd, mem_wr}, 32'd1);
      if (was_done)
        check(mem_rd || mem_wr, "R10", "start in done cycle", {30'd0, mem_rd, mem_wr}, 32'd1);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd || mem_wr) begin
        if (acc_q.size() == 0) begin
          check(1'b0, "R9", "unexpected access", {7'd0, mem_wr, mem_addr, mem_wdata}, 32'd0);
        end else begin
          logic [24:0] e;
          logic [24:0] a;
          string t;
          e = acc_q.pop_front();
          t = acc_tag.pop_front();
          a = {mem_wr, mem_addr, mem_wr ? mem_wdata : 8'h00};
          check(a == e, t, "access", {7'd0, a}, {7'd0, e});
        end
        if (mem_wr) dut_mem[mem_addr] = mem_wdata;
        else        mem_rdata = rd_of(1'b0, mem_addr);
      end
      if (done) begin
        if (fin_q.size() == 0) begin
          check(1'b0, "R9", "unexpected done", {pc_out, sp_out, status_out}, 32'd0);
        end else begin
          logic [31:0] f;
          string t;
          f = fin_q.pop_front();
          t = fin_tag.pop_front();
          check({pc_out, sp_out, status_out} == f, t, "final pc/sp/status",
                {pc_out, sp_out, status_out}, f);
        end
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    preload(16'hFFFE, 8'h00); preload(16'hFFFF, 8'h80);
    preload(16'hFFFA, 8'h00); preload(16'hFFFB, 8'hC0);
    preload(16'h0100, 8'h34); preload(16'h0101, 8'h12);
    preload(16'h0102, 8'hC3); preload(16'h0103, 8'h55); preload(16'h0104, 8'h66);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(pc_out == 16'h0000, "R1", "reset pc", {16'd0, pc_out}, 32'h0);
    check(sp_out == 8'hFF, "R1", "reset sp", {24'd0, sp_out}, 32'hFF);
    check(status_out == 8'h04, "R1", "reset status", {24'd0, status_out}, 32'h04);
    check({busy, done, mem_rd, mem_wr} == 4'b0, "R1", "reset controls",
          {28'd0, busy, done, mem_rd, mem_wr}, 32'h0);

    issue(3'd5, 16'h1111, 16'h2222, 1'b0);
    issue(3'd7, 16'h3333, 16'h4444, 1'b0);
    repeat (4) @(negedge clk);
    check(!busy && !done, "R9", "invalid op idle", {30'd0, busy, done}, 32'h0);
    check({pc_out, sp_out, status_out} == 32'h0000FF04, "R9", "invalid op state",
          {pc_out, sp_out, status_out}, 32'h0000FF04);

    issue(3'd1, 16'h0000, 16'h0000, 1'b1);   // R3, R7 pop wraps 0xFF->0x00
    issue(3'd2, 16'hABCD, 16'h0000, 1'b1);   // R4, R7 push wraps 0x00->0xFF
    issue(3'd0, 16'h8002, 16'h9000, 1'b1);   // R2, R10
    issue(3'd1, 16'h0000, 16'h0000, 1'b1);   // R3, R10
    issue(3'd3, 16'h0000, 16'h0000, 1'b1);   // R5
    issue(3'd3, 16'h0000, 16'h0000, 1'b1);   // R5 status with bit 2 clear
    issue(3'd4, 16'h6655, 16'h0000, 1'b1);   // R6
    issue(3'd0, 16'hC002, 16'hD000, 1'b1);   // R2
    req_valid = 1'b1; req_op = 3'd3;          // R9 request while busy
    @(negedge clk);
    req_valid = 1'b0;
    repeat (10) @(negedge clk);
    check(!busy, "R9", "busy request dropped", {31'd0, busy}, 32'h0);
    check(acc_q.size() == 0 && fin_q.size() == 0, "R8", "all expected items seen",
          acc_q.size() + fin_q.size(), 32'h0);
    check({pc_out, sp_out, status_out} == {pc_m, sp_m, st_m}, "R9", "state after dropped request",
          {pc_out, sp_out, status_out}, {pc_m, sp_m, st_m});
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R8 watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

endmodule